// File: doc/BRIEF.md
# Banked Scratchpad Conflict Arbiter

This block sits in front of a shared scratchpad that is split into word-interleaved banks. A group of threads presents one word request each (address, read/write flag, write data, valid bit) together with a one-cycle start strobe. The block latches the group and sorts the requests by bank. Threads that name the same word are served together as a broadcast. Threads that name different words in one bank are replayed over as many cycles as that bank needs.

In each cycle the block drives one row per bank into a banked RAM model that it contains. It raises a per-thread grant for every thread served in that cycle. One cycle later it returns the read word on that thread's data lane. When the last pending thread has been served, it pulses a completion flag and reports how many cycles the group took. A second start that arrives while a group is in progress is dropped.

Top module: `smem_conflict_arbiter`

## Requirements
- R1: After reset, busy_o, done_o, grant_o, bank_en_o and rvalid_o are all zero, and every scratchpad word reads as zero.
- R2: The bank of a request is given by the low log2(NUM_BANKS) address bits (address modulo 16 by default). A group in which every valid thread uses a different bank completes in one cycle, for any assignment of threads to banks.
- R3: Threads that request an identical address are granted in the same cycle. Each of them sees rvalid_o set one cycle after its grant, with the same word on its rdata_o lane.
- R4: A group that mixes broadcast readers, unique accesses and unused banks, with at most one distinct address per bank, completes in one cycle.
- R5: Distinct addresses in one bank are served in separate cycles. The number of busy cycles, reported on cycles_o while done_o is high, equals the largest count of distinct addresses found in any single bank.
- R6: In every cycle, the lowest-numbered pending thread in each bank chooses that bank's address, and every pending thread with the same address is granted with it. A thread is therefore served in the cycle equal to the rank of its address among the distinct addresses of its bank, ranked by the first thread that uses each address.
- R7: bank_en_o bit b is high in a cycle exactly when some thread whose address falls in bank b is granted in that cycle.
- R8: When several granted threads write one address, the data of the highest-numbered writer is stored. Reads granted in the same cycle return the value held before that cycle's write.
- R9: start_i is ignored while busy_o is high. A start with no valid thread produces done_o on the next cycle with cycles_o equal to zero and no grants.
- R10: done_o pulses for one cycle, in the cycle after the last grant cycle, with busy_o low. Every valid thread is granted exactly once per group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Latch a new group (taken only while idle) |
| valid_i | input | NUM_THREADS | Per-thread request valid |
| addr_i | input | NUM_THREADS*ADDR_W | Per-thread word address, thread t at bits [t*ADDR_W +: ADDR_W] |
| we_i | input | NUM_THREADS | Per-thread write flag |
| wdata_i | input | NUM_THREADS*DATA_W | Per-thread write data |
| busy_o | output | 1 | A group is being served |
| grant_o | output | NUM_THREADS | Threads served in the current cycle |
| bank_en_o | output | NUM_BANKS | Banks accessed in the current cycle |
| rvalid_o | output | NUM_THREADS | Threads whose read word is on rdata_o (one cycle after grant) |
| rdata_o | output | NUM_THREADS*DATA_W | Per-thread read word |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | $clog2(NUM_THREADS+1) | Cycles taken by the finished group |

## Verification
The bench targets the cases where a naive arbiter over-serializes or under-serializes. If equal addresses were counted as conflicts, a full broadcast or a partial broadcast would take extra cycles. If conflicts were detected per thread instead of per address, a broadcast pair sharing a bank with a third address would collapse to one cycle and return wrong data. A group with sixteen different rows in one bank checks the longest replay and the cycle count. It also carries a second start that must be dropped. A multi-writer group followed by a read-back shows whether the wrong writer won, or whether a read in the same cycle saw the new value. Random groups squeezed into a few rows or a handful of addresses check the per-cycle grant order and bank enables against a ranking computed in the bench.

// File: rtl/smem_arb_pkg.sv
package smem_arb_pkg;

   localparam int unsigned DEF_THREADS = 16;
   localparam int unsigned DEF_BANKS   = 16;
   localparam int unsigned DEF_ADDR_W  = 8;
   localparam int unsigned DEF_DATA_W  = 32;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/smem_grant_logic.sv
module smem_grant_logic #(
   parameter int unsigned NUM_THREADS = 16,
   parameter int unsigned NUM_BANKS   = 16,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   localparam int unsigned BANK_BITS  = $clog2(NUM_BANKS),
   localparam int unsigned ROW_W      = ADDR_W - BANK_BITS
) (
   input  logic [NUM_THREADS-1:0]             pending,
   input  logic [NUM_THREADS-1:0][ADDR_W-1:0] addr,
   input  logic [NUM_THREADS-1:0]             we,
   input  logic [NUM_THREADS-1:0][DATA_W-1:0] wdata,
   output logic [NUM_THREADS-1:0]             grant,
   output logic [NUM_BANKS-1:0]               bank_en,
   output logic [NUM_BANKS-1:0][ROW_W-1:0]    bank_row,
   output logic [NUM_BANKS-1:0]               bank_we,
   output logic [NUM_BANKS-1:0][DATA_W-1:0]   bank_wdata
);

   logic [NUM_BANKS-1:0][ADDR_W-1:0] lead_addr;
   logic [NUM_BANKS-1:0]             lead_hit;

   // Per bank: the lowest-numbered pending thread picks the address.
   // Scanning downward lets the lowest index assign last.
   always_comb begin
      lead_hit  = '0;
      lead_addr = '0;
      for (int t = NUM_THREADS - 1; t >= 0; t--) begin
         if (pending[t]) begin
            lead_hit[addr[t][BANK_BITS-1:0]]  = 1'b1;
            lead_addr[addr[t][BANK_BITS-1:0]] = addr[t];
         end
      end
   end

   // Every pending thread whose address matches its bank's choice rides along.
   always_comb begin
      for (int t = 0; t < NUM_THREADS; t++) begin
         grant[t] = pending[t] && (addr[t] == lead_addr[addr[t][BANK_BITS-1:0]]);
      end
   end

   always_comb begin
      for (int b = 0; b < NUM_BANKS; b++) begin
         bank_row[b] = lead_addr[b][ADDR_W-1:BANK_BITS];
      end
   end

   assign bank_en = lead_hit;

   // Writers to one word: the highest-numbered granted writer assigns last.
   always_comb begin
      bank_we    = '0;
      bank_wdata = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
         if (grant[t] && we[t]) begin
            bank_we[addr[t][BANK_BITS-1:0]]    = 1'b1;
            bank_wdata[addr[t][BANK_BITS-1:0]] = wdata[t];
         end
      end
   end

endmodule

// File: rtl/smem_bank.sv
module smem_bank #(
   parameter int unsigned ROW_W  = 4,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned ROWS  = 1 << ROW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ROW_W-1:0]  row,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [ROWS-1:0][DATA_W-1:0] mem_q;

   // Read is combinational. The caller registers it at the same edge
   // that commits a write, so a read sees the value before the write.
   assign rdata = mem_q[row];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= '0;
      end else if (we) begin
         mem_q[row] <= wdata;
      end
   end

endmodule

// File: rtl/smem_conflict_arbiter.sv
module smem_conflict_arbiter
   import smem_arb_pkg::*;
#(
   parameter int unsigned NUM_THREADS = DEF_THREADS,
   parameter int unsigned NUM_BANKS   = DEF_BANKS,
   parameter int unsigned ADDR_W      = DEF_ADDR_W,
   parameter int unsigned DATA_W      = DEF_DATA_W,
   localparam int unsigned BANK_BITS  = $clog2(NUM_BANKS),
   localparam int unsigned ROW_W      = ADDR_W - BANK_BITS,
   localparam int unsigned CNT_W      = $clog2(NUM_THREADS + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start_i,
   input  logic [NUM_THREADS-1:0]        valid_i,
   input  logic [NUM_THREADS*ADDR_W-1:0] addr_i,
   input  logic [NUM_THREADS-1:0]        we_i,
   input  logic [NUM_THREADS*DATA_W-1:0] wdata_i,
   output logic                          busy_o,
   output logic [NUM_THREADS-1:0]        grant_o,
   output logic [NUM_BANKS-1:0]          bank_en_o,
   output logic [NUM_THREADS-1:0]        rvalid_o,
   output logic [NUM_THREADS*DATA_W-1:0] rdata_o,
   output logic                          done_o,
   output logic [CNT_W-1:0]              cycles_o
);

   // Elaboration-time parameter checks
   if (!is_pow2(NUM_BANKS) || NUM_BANKS < 2) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two and at least 2");
   end
   if (ADDR_W <= BANK_BITS) begin : g_bad_addr
      $error("ADDR_W must exceed log2(NUM_BANKS)");
   end
   if (ROW_W > 12) begin : g_bad_depth
      $error("bank depth too large for the RAM model");
   end
   if (NUM_THREADS < 1) begin : g_bad_threads
      $error("NUM_THREADS must be at least 1");
   end

   logic                                 busy_q;
   logic [NUM_THREADS-1:0]               pend_q;
   logic [NUM_THREADS-1:0][ADDR_W-1:0]   addr_q;
   logic [NUM_THREADS-1:0]               we_q;
   logic [NUM_THREADS-1:0][DATA_W-1:0]   wdata_q;
   logic [CNT_W-1:0]                     cnt_q;
   logic                                 done_q;
   logic [CNT_W-1:0]                     cycles_q;
   logic [NUM_THREADS-1:0]               rvalid_q;
   logic [NUM_THREADS-1:0][DATA_W-1:0]   rdata_q;

   logic [NUM_THREADS-1:0]               grant;
   logic [NUM_BANKS-1:0]                 bank_en;
   logic [NUM_BANKS-1:0][ROW_W-1:0]      bank_row;
   logic [NUM_BANKS-1:0]                 bank_we;
   logic [NUM_BANKS-1:0][DATA_W-1:0]     bank_wdata;
   logic [NUM_BANKS-1:0][DATA_W-1:0]     bank_rdata;
   logic [NUM_THREADS-1:0][DATA_W-1:0]   rd_bus;
   logic [NUM_THREADS-1:0]               pend_next;

   smem_grant_logic #(
      .NUM_THREADS (NUM_THREADS),
      .NUM_BANKS   (NUM_BANKS),
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W)
   ) i_grant (
      .pending    (pend_q),
      .addr       (addr_q),
      .we         (we_q),
      .wdata      (wdata_q),
      .grant      (grant),
      .bank_en    (bank_en),
      .bank_row   (bank_row),
      .bank_we    (bank_we),
      .bank_wdata (bank_wdata)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      smem_bank #(
         .ROW_W  (ROW_W),
         .DATA_W (DATA_W)
      ) i_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .row   (bank_row[b]),
         .we    (bank_we[b]),
         .wdata (bank_wdata[b]),
         .rdata (bank_rdata[b])
      );
   end

   // Route each bank's read word back to every thread addressing that bank
   always_comb begin
      for (int t = 0; t < NUM_THREADS; t++) begin
         rd_bus[t] = bank_rdata[addr_q[t][BANK_BITS-1:0]];
      end
   end

   assign pend_next = pend_q & ~grant;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         pend_q   <= '0;
         addr_q   <= '0;
         we_q     <= '0;
         wdata_q  <= '0;
         cnt_q    <= '0;
         done_q   <= 1'b0;
         cycles_q <= '0;
         rvalid_q <= '0;
         rdata_q  <= '0;
      end else begin
         done_q   <= 1'b0;
         rvalid_q <= grant;
         for (int t = 0; t < NUM_THREADS; t++) begin
            if (grant[t]) rdata_q[t] <= rd_bus[t];
         end
         if (!busy_q && start_i) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
               addr_q[t]  <= addr_i[t*ADDR_W +: ADDR_W];
               wdata_q[t] <= wdata_i[t*DATA_W +: DATA_W];
            end
            we_q <= we_i;
            if (valid_i == '0) begin
               done_q   <= 1'b1;
               cycles_q <= '0;
            end else begin
               busy_q <= 1'b1;
               pend_q <= valid_i;
               cnt_q  <= '0;
            end
         end else if (busy_q) begin
            pend_q <= pend_next;
            cnt_q  <= cnt_q + 1'b1;
            if (pend_next == '0) begin
               busy_q   <= 1'b0;
               done_q   <= 1'b1;
               cycles_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign busy_o    = busy_q;
   assign grant_o   = grant;
   assign bank_en_o = bank_en;
   assign rvalid_o  = rvalid_q;
   assign done_o    = done_q;
   assign cycles_o  = cycles_q;

   always_comb begin
      for (int t = 0; t < NUM_THREADS; t++) begin
         rdata_o[t*DATA_W +: DATA_W] = rdata_q[t];
      end
   end

   // A busy cycle always serves at least one thread (R5)
   assert_progress_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (grant_o != '0));

   // The reported count never exceeds the thread count (R5)
   assert_cycles_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cycles_o <= CNT_W'(NUM_THREADS)));

   // A grant always comes with an enabled bank (R7)
   assert_bank_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_o != '0) |-> (bank_en_o != '0));

   // Completion is reported only once the block is idle (R10)
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // No thread is served twice in consecutive busy cycles (R10)
   assert_no_regrant_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> ((grant_o & $past(grant_o)) == '0));

   // A start during a busy group neither aborts it nor restarts it (R9)
   assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && (pend_next != '0)) |=> (busy_o && !done_o));

endmodule

// File: tb/test_smem_conflict_arbiter.sv
module test_smem_conflict_arbiter;

   localparam int T  = 16;
   localparam int B  = 16;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int CW = $clog2(T + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [T-1:0]      valid_i = '0;
   logic [T*AW-1:0]   addr_i = '0;
   logic [T-1:0]      we_i = '0;
   logic [T*DW-1:0]   wdata_i = '0;
   logic              busy_o;
   logic [T-1:0]      grant_o;
   logic [B-1:0]      bank_en_o;
   logic [T-1:0]      rvalid_o;
   logic [T*DW-1:0]   rdata_o;
   logic              done_o;
   logic [CW-1:0]     cycles_o;

   smem_conflict_arbiter i_smem_conflict_arbiter (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .valid_i (valid_i),
      .addr_i (addr_i), .we_i (we_i), .wdata_i (wdata_i), .busy_o (busy_o),
      .grant_o (grant_o), .bank_en_o (bank_en_o), .rvalid_o (rvalid_o),
      .rdata_o (rdata_o), .done_o (done_o), .cycles_o (cycles_o)
   );

   always #5 clk = ~clk;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc_cnt  = 0;

   logic [DW-1:0] mem_m [256];
   bit            g_val [T];
   bit            g_we  [T];
   int            g_addr[T];
   logic [DW-1:0] g_wd  [T];
   int            g_rank[T];
   int            g_ncyc;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc_cnt++;
      if (cyc_cnt > 150000) begin
         n_fail++;
         $display("FAIL R10 watchdog expired actual=%0d expected<150000", cyc_cnt);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   // Rank of each thread's address within its bank, ordered by first user
   task automatic compute_expected();
      g_ncyc = 0;
      for (int t = 0; t < T; t++) begin
         int first;
         g_rank[t] = -1;
         if (!g_val[t]) continue;
         first = t;
         for (int u = t - 1; u >= 0; u--)
            if (g_val[u] && g_addr[u] == g_addr[t]) first = u;
         g_rank[t] = 0;
         for (int u = 0; u < first; u++) begin
            bit is_first = 1'b1;
            if (!g_val[u] || (g_addr[u] % B) != (g_addr[t] % B) || g_addr[u] == g_addr[t]) continue;
            for (int v = 0; v < u; v++)
               if (g_val[v] && g_addr[v] == g_addr[u]) is_first = 1'b0;
            if (is_first) g_rank[t]++;
         end
         if (g_rank[t] + 1 > g_ncyc) g_ncyc = g_rank[t] + 1;
      end
   endtask

   function automatic logic [T-1:0] exp_grant(input int k);
      logic [T-1:0] m = '0;
      for (int t = 0; t < T; t++) if (g_val[t] && g_rank[t] == k) m[t] = 1'b1;
      return m;
   endfunction

   function automatic logic [B-1:0] exp_banks(input int k);
      logic [B-1:0] m = '0;
      for (int t = 0; t < T; t++) if (g_val[t] && g_rank[t] == k) m[g_addr[t] % B] = 1'b1;
      return m;
   endfunction

   task automatic run_group(input string ctag, input string dtag, input bit poke);
      logic [DW-1:0] old_m [T];
      compute_expected();
      for (int t = 0; t < T; t++) old_m[t] = mem_m[g_addr[t]];
      @(negedge clk);
      for (int t = 0; t < T; t++) begin
         valid_i[t] = g_val[t];
         we_i[t]    = g_we[t];
         addr_i[t*AW +: AW] = AW'(g_addr[t]);
         wdata_i[t*DW +: DW] = g_wd[t];
      end
      start_i = 1'b1;
      for (int k = 0; k <= g_ncyc; k++) begin
         @(negedge clk);
         start_i = 1'b0;
         if (poke && k == 0) begin
            start_i = 1'b1;
            valid_i = '1;
            addr_i  = {T{8'h00}};
            we_i    = '1;
         end
         if (k < g_ncyc) begin
            chk(busy_o == 1'b1, "R10 busy during group", 64'(busy_o), 64'd1);
            chk(grant_o == exp_grant(k), "R6 grant mask", 64'(grant_o), 64'(exp_grant(k)));
            chk(bank_en_o == exp_banks(k), "R7 bank enables", 64'(bank_en_o), 64'(exp_banks(k)));
         end else begin
            chk(busy_o == 1'b0 && done_o == 1'b1, "R10 completion", {busy_o, done_o}, 64'b01);
            chk(cycles_o == CW'(g_ncyc), {ctag, " R5 cycle count"}, 64'(cycles_o), 64'(g_ncyc));
         end
         if (k > 0) begin
            chk(rvalid_o == exp_grant(k - 1), "R3 read valid", 64'(rvalid_o), 64'(exp_grant(k - 1)));
            for (int t = 0; t < T; t++) begin
               if (g_val[t] && g_rank[t] == k - 1)
                  chk(rdata_o[t*DW +: DW] == old_m[t], {dtag, " read data"},
                      64'(rdata_o[t*DW +: DW]), 64'(old_m[t]));
            end
         end else begin
            chk(rvalid_o == '0, "R3 no early read valid", 64'(rvalid_o), 64'd0);
         end
      end
      if (poke) begin
         @(negedge clk);
         chk(busy_o == 1'b0 && done_o == 1'b0, "R9 start while busy ignored", {busy_o, done_o}, 64'd0);
      end
      for (int t = 0; t < T; t++) if (g_val[t] && g_we[t]) mem_m[g_addr[t]] = g_wd[t];
   endtask

   task automatic clear_group();
      for (int t = 0; t < T; t++) begin
         g_val[t] = 1'b0; g_we[t] = 1'b0; g_addr[t] = 0; g_wd[t] = '0;
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 256; i++) mem_m[i] = '0;
      repeat (3) @(negedge clk);
      chk(busy_o == 0 && done_o == 0 && grant_o == 0 && bank_en_o == 0 && rvalid_o == 0,
          "R1 reset outputs", {busy_o, done_o, grant_o, bank_en_o, rvalid_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy_o == 0 && done_o == 0, "R1 idle after reset", {busy_o, done_o}, 64'd0);

      // Fill memory so reads return distinct values
      for (int r = 0; r < 16; r++) begin
         clear_group();
         for (int t = 0; t < T; t++) begin
            g_val[t] = 1'b1; g_we[t] = 1'b1;
            g_addr[t] = r * 16 + t; g_wd[t] = 32'hA500_0000 + 32'(r * 16 + t);
         end
         run_group("R2", "R1", 1'b0);
      end

      // R2: every thread in a different bank, scrambled order
      clear_group();
      for (int t = 0; t < T; t++) begin
         g_val[t] = 1'b1; g_addr[t] = ((t * 5 + 3) % 16) + 16 * (t % 7);
      end
      run_group("R2", "R2", 1'b0);

      // R3: full broadcast of one word
      clear_group();
      for (int t = 0; t < T; t++) begin g_val[t] = 1'b1; g_addr[t] = 37; end
      run_group("R3", "R3", 1'b0);

      // R4: partial broadcast, unique accesses, idle banks
      clear_group();
      for (int t = 0; t < 6; t++) begin g_val[t] = 1'b1; g_addr[t] = 50; end
      for (int t = 6; t < 10; t++) begin g_val[t] = 1'b1; g_addr[t] = (t - 3) + 16 * t; end
      run_group("R4", "R4", 1'b0);

      // R5 and R9: sixteen rows in one bank, with a start during the replay
      clear_group();
      for (int t = 0; t < T; t++) begin g_val[t] = 1'b1; g_addr[t] = t * 16 + 5; end
      run_group("R5", "R5", 1'b1);

      // R5 and R6: broadcast pair plus a conflicting row in the same bank
      clear_group();
      g_val[0] = 1; g_addr[0] = 4;
      g_val[1] = 1; g_addr[1] = 4;
      g_val[2] = 1; g_addr[2] = 20;
      g_val[3] = 1; g_addr[3] = 4;
      run_group("R5", "R6", 1'b0);

      // R6: lowest thread picks its address first
      clear_group();
      g_val[0] = 1; g_addr[0] = 36;
      g_val[1] = 1; g_addr[1] = 4;
      g_val[2] = 1; g_addr[2] = 4;
      run_group("R6", "R6", 1'b0);

      // R8: multiple writers and a reader on one word, then read back
      clear_group();
      for (int t = 0; t < 4; t++) begin
         g_val[t] = 1; g_we[t] = 1; g_addr[t] = 77; g_wd[t] = 32'hC0DE_0000 + 32'(t);
      end
      g_val[4] = 1; g_addr[4] = 77;
      run_group("R8", "R8", 1'b0);
      clear_group();
      g_val[9] = 1; g_addr[9] = 77;
      run_group("R8", "R8", 1'b0);
      chk(mem_m[77] == 32'hC0DE_0003, "R8 model highest writer", 64'(mem_m[77]), 64'hC0DE_0003);

      // R9: empty start
      clear_group();
      run_group("R9", "R9", 1'b0);

      // Random groups with varied address spread
      for (int n = 0; n < 300; n++) begin
         int mode = int'($urandom % 3);
         int pool[4];
         for (int i = 0; i < 4; i++) pool[i] = int'($urandom % 256);
         clear_group();
         for (int t = 0; t < T; t++) begin
            g_val[t] = ($urandom % 5) != 0;
            g_we[t]  = ($urandom % 4) == 0;
            g_wd[t]  = $urandom;
            case (mode)
               0:       g_addr[t] = int'($urandom % 256);
               1:       g_addr[t] = int'($urandom % 64);
               default: g_addr[t] = pool[$urandom % 4];
            endcase
         end
         run_group("R5", "R3", 1'b0);
      end

      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule